// File: doc/BRIEF.md
# Multiply-Accumulate Unit with HI/LO Accumulator

This execution unit sits in a 64-bit integer pipeline. It multiplies two 32-bit operands and folds the product into a 64-bit accumulator. The accumulator is split across two 64-bit architectural registers, HI and LO. The accumulator's upper word is HI bits [31:0] and its lower word is LO bits [31:0]. Each issued instruction word is decoded in the same cycle. The product is formed and combined with the current accumulator in one of four ways. The new value is offered as a register write-back, and HI/LO take the new accumulator on the next rising clock edge.

The pipeline supplies the instruction word and the two 64-bit source register values. Only the low 32 bits of each source are used. Each operation can be signed or unsigned, and each can return either the upper or the lower word of the new accumulator. The returned word is sign-extended to 64 bits. An instruction word that does not decode to one of the supported forms raises an illegal flag and changes nothing.

Top module: `macc_unit`

## Requirements
- R1: After reset, hi_q and lo_q are zero. With issue_valid low, wb_valid and illegal are both low.
- R2: The accumulator is {hi_q[31:0], lo_q[31:0]}. An accepted instruction writes only those two low words. hi_q[63:32] and lo_q[63:32] keep their previous value, which is zero from reset.
- R3: Function code instr[5:0] = 6'b011000 selects signed operation. The product is the 64-bit two's-complement product of src_a[31:0] and src_b[31:0]. Source bits [63:32] have no effect.
- R4: Function code instr[5:0] = 6'b011001 selects unsigned operation. The product is the 64-bit product of the zero-extended src_a[31:0] and src_b[31:0].
- R5: The operation field instr[10:6] is legal only when bit 6 is 1 and bit 10 is 0. Bits [8:7] select the kind: 00 sets acc = product, 01 sets acc = 0 - product, 10 sets acc = acc + product, 11 sets acc = acc - product.
- R6: Field bit 9 (instr[9]) selects the write-back word: 1 selects the new accumulator bits [63:32], and 0 selects bits [31:0]. wb_data is that word sign-extended to 64 bits, and wb_rd equals instr[15:11].
- R7: Accumulation wraps modulo 2^64 with no trap or flag.
- R8: An issued word is illegal if any of these holds: instr[31:26] is not 000000, the function code is neither of the two, or the field is not legal. An illegal word drives illegal high and wb_valid low in the same cycle, and leaves hi_q and lo_q unchanged.
- R9: While issue_valid is low, wb_valid and illegal stay low and hi_q and lo_q do not change.
- R10: wb_valid and wb_data respond in the same cycle as the issue. hi_q and lo_q show the new accumulator after the next rising clock edge, so back-to-back instructions chain through it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction word is presented this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 64 | First source register value |
| src_b | input | 64 | Second source register value |
| wb_valid | output | 1 | Register write-back is valid this cycle |
| wb_rd | output | 5 | Destination register index |
| wb_data | output | 64 | Sign-extended write-back word |
| illegal | output | 1 | Issued word is not a supported form |
| hi_q | output | 64 | HI register |
| lo_q | output | 64 | LO register |

## Verification
The bench sweeps all sixteen combinations of sign, kind and write-back word against operands at the sign boundaries, and carries its own accumulator across the chain. This catches a design that sign-extends unsigned operands, that takes a source's upper bits into the product, or that swaps the meaning of the kind bits. A forced wrap, in which a large unsigned product is added twice, exposes an accumulator that saturates or keeps a carry. All 32 field values, plus a bad opcode and bad function codes, are issued after a nonzero accumulator has been built up, so a design that commits on an illegal word shows a changed HI or LO. The write-back word is checked in both halves with negative values, which shows a missing sign extension or a swapped half.

// File: rtl/macc_pkg.sv
package macc_pkg;
  localparam int OPW  = 32;
  localparam int ACCW = 2 * OPW;

  typedef enum logic [1:0] {
    KIND_MUL = 2'b00,
    KIND_NEG = 2'b01,
    KIND_ADD = 2'b10,
    KIND_SUB = 2'b11
  } kind_e;

  typedef struct packed {
    logic       legal;
    logic       is_signed;
    logic       sel_hi;
    kind_e      kind;
    logic [4:0] rd;
  } dec_t;

  // Widen both operands to the accumulator width, then multiply.
  function automatic logic [ACCW-1:0] mac_product(input logic [OPW-1:0] a,
                                                  input logic [OPW-1:0] b,
                                                  input logic is_signed);
    logic [ACCW-1:0] wa, wb;
    wa = is_signed ? {{OPW{a[OPW-1]}}, a} : {{OPW{1'b0}}, a};
    wb = is_signed ? {{OPW{b[OPW-1]}}, b} : {{OPW{1'b0}}, b};
    return wa * wb;
  endfunction

  // Fold the product into the accumulator; wraps modulo 2^ACCW.
  function automatic logic [ACCW-1:0] mac_combine(input logic [ACCW-1:0] acc,
                                                  input logic [ACCW-1:0] prod,
                                                  input kind_e kind);
    case (kind)
      KIND_MUL: return prod;
      KIND_NEG: return '0 - prod;
      KIND_ADD: return acc + prod;
      default:  return acc - prod;
    endcase
  endfunction
endpackage

// File: rtl/macc_decode.sv
module macc_decode
  import macc_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);
  logic [4:0] field;
  logic [5:0] funct;
  logic       op_ok, fn_ok, field_ok;
  logic       unused_rs_rt;

  assign field    = instr[10:6];
  assign funct    = instr[5:0];
  assign op_ok    = (instr[31:26] == 6'b000000);
  assign fn_ok    = (funct[5:1] == 5'b01100);
  assign field_ok = field[0] & ~field[4];
  assign unused_rs_rt = ^instr[25:16];

  always_comb begin
    dec.legal     = op_ok & fn_ok & field_ok;
    dec.is_signed = ~funct[0];
    dec.sel_hi    = field[3];
    dec.kind      = kind_e'(field[2:1]);
    dec.rd        = instr[15:11];
  end
endmodule

// File: rtl/macc_arith.sv
module macc_arith
  import macc_pkg::*;
(
  input  logic [OPW-1:0]  op_a,
  input  logic [OPW-1:0]  op_b,
  input  logic [ACCW-1:0] acc_cur,
  input  logic            is_signed,
  input  kind_e           kind,
  output logic [ACCW-1:0] product,
  output logic [ACCW-1:0] acc_next
);
  assign product  = mac_product(op_a, op_b, is_signed);
  assign acc_next = mac_combine(acc_cur, product, kind);
endmodule

// File: rtl/macc_hilo.sv
module macc_hilo
  import macc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [ACCW-1:0] acc_in,
  output logic [XLEN-1:0] hi_q,
  output logic [XLEN-1:0] lo_q,
  output logic [ACCW-1:0] acc_cur
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (wr_en) begin
      hi_q <= {hi_q[XLEN-1:OPW], acc_in[ACCW-1:OPW]};
      lo_q <= {lo_q[XLEN-1:OPW], acc_in[OPW-1:0]};
    end
  end

  assign acc_cur = {hi_q[OPW-1:0], lo_q[OPW-1:0]};
endmodule

// File: rtl/macc_unit.sv
module macc_unit
  import macc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic            wb_valid,
  output logic [4:0]      wb_rd,
  output logic [XLEN-1:0] wb_data,
  output logic            illegal,
  output logic [XLEN-1:0] hi_q,
  output logic [XLEN-1:0] lo_q
);
  dec_t            dec;
  logic [ACCW-1:0] acc_cur, acc_next, product;
  logic [OPW-1:0]  wb_word;
  logic            commit;
  logic            unused_src_hi;

  macc_decode u_dec (.instr(instr), .dec(dec));

  macc_arith u_arith (
    .op_a(src_a[OPW-1:0]), .op_b(src_b[OPW-1:0]), .acc_cur(acc_cur),
    .is_signed(dec.is_signed), .kind(dec.kind),
    .product(product), .acc_next(acc_next)
  );

  macc_hilo #(.XLEN(XLEN)) u_hilo (
    .clk(clk), .rst_n(rst_n), .wr_en(commit), .acc_in(acc_next),
    .hi_q(hi_q), .lo_q(lo_q), .acc_cur(acc_cur)
  );

  assign unused_src_hi = ^{src_a[XLEN-1:OPW], src_b[XLEN-1:OPW]};
  assign commit   = issue_valid & dec.legal;
  assign wb_valid = commit;
  assign illegal  = issue_valid & ~dec.legal;
  assign wb_rd    = dec.rd;
  assign wb_word  = dec.sel_hi ? acc_next[ACCW-1:OPW] : acc_next[OPW-1:0];
  assign wb_data  = {{(XLEN-OPW){wb_word[OPW-1]}}, wb_word};

  // R2: upper halves of HI/LO never move
  assert_upper_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(hi_q[XLEN-1:OPW]) && $stable(lo_q[XLEN-1:OPW])));

  // R8: illegal word leaves HI/LO as they were
  assert_illegal_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> ($stable(hi_q) && $stable(lo_q)));

  // R9: idle cycle leaves HI/LO as they were
  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> ($stable(hi_q) && $stable(lo_q)));

  // R6: write-back is sign-extended
  assert_wb_sext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_data[XLEN-1:OPW] == {(XLEN-OPW){wb_data[OPW-1]}}));

  // R10: the written-back word is what lands in the selected register
  assert_wb_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && dec.sel_hi) |=> (hi_q[OPW-1:0] == $past(wb_data[OPW-1:0])));
  assert_wb_lands_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !dec.sel_hi) |=> (lo_q[OPW-1:0] == $past(wb_data[OPW-1:0])));

  // R5: plain multiply loads the product into the accumulator
  assert_mul_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && dec.kind == KIND_MUL) |=>
      ({hi_q[OPW-1:0], lo_q[OPW-1:0]} == $past(product)));

  // R8: flags are exclusive
  assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_valid && illegal));
endmodule

// File: tb/macc_unit_test.sv
module macc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] src_a = '0, src_b = '0;
  logic        wb_valid, illegal;
  logic [4:0]  wb_rd;
  logic [63:0] wb_data, hi_q, lo_q;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [63:0] m_acc = '0;
  logic [31:0] seed = 32'h1234_5678;

  macc_unit uut (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_instr(input bit uns, input logic [4:0] fld,
                                           input logic [4:0] rd);
    return {6'b000000, 5'd3, 5'd4, rd, fld, 5'b01100, uns};
  endfunction

  task automatic check_regs(input string tag);
    chk(hi_q == {32'h0, m_acc[63:32]}, {tag, " HI"}, hi_q, {32'h0, m_acc[63:32]});
    chk(lo_q == {32'h0, m_acc[31:0]}, {tag, " LO"}, lo_q, {32'h0, m_acc[31:0]});
  endtask

  // Issue one legal instruction and check against the bench's own model.
  task automatic do_op(input bit uns, input bit hi, input logic [1:0] kind,
                       input logic [63:0] a, input logic [63:0] b, input string tag);
    longint          sp;
    longint unsigned up, prod, nxt;
    logic [31:0]     w;
    logic [4:0]      rd;
    rd = a[4:0] ^ b[9:5];
    sp = longint'($signed(a[31:0])) * longint'($signed(b[31:0]));
    up = longint'({32'h0, a[31:0]}) * longint'({32'h0, b[31:0]});
    prod = uns ? up : longint'(sp);
    case (kind)
      2'b00: nxt = prod;
      2'b01: nxt = 64'd0 - prod;
      2'b10: nxt = m_acc + prod;
      default: nxt = m_acc - prod;
    endcase
    w = hi ? nxt[63:32] : nxt[31:0];
    @(negedge clk);
    issue_valid = 1'b1;
    instr = mk_instr(uns, {1'b0, hi, kind, 1'b1}, rd);
    src_a = a;
    src_b = b;
    #1;
    chk(wb_valid === 1'b1 && illegal === 1'b0, {tag, " valid"}, {62'h0, wb_valid, illegal}, 64'h2);
    chk(wb_data == {{32{w[31]}}, w}, {tag, " wb_data"}, wb_data, {{32{w[31]}}, w});
    chk(wb_rd == rd, {tag, " rd R6"}, {59'h0, wb_rd}, {59'h0, rd});
    @(negedge clk);
    issue_valid = 1'b0;
    m_acc = nxt;
    check_regs({tag, " regs R10"});
  endtask

  task automatic do_bad(input logic [31:0] iw, input string tag);
    @(negedge clk);
    issue_valid = 1'b1;
    instr = iw;
    src_a = 64'h0000_0000_0000_0007;
    src_b = 64'h0000_0000_0000_0009;
    #1;
    chk(illegal === 1'b1 && wb_valid === 1'b0, {tag, " flags R8"}, {62'h0, wb_valid, illegal}, 64'h1);
    @(negedge clk);
    issue_valid = 1'b0;
    check_regs({tag, " unchanged R8"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(hi_q == 0 && lo_q == 0, "R1 regs zero", hi_q ^ lo_q, 64'h0);
    chk(!wb_valid && !illegal, "R1 flags low", {62'h0, wb_valid, illegal}, 64'h0);

    // R3 R4 R5 R6: sweep all 16 sign/kind/half combinations
    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m < 8; m++) begin
        logic [63:0] pa [6];
        logic [63:0] pb [6];
        pa[0] = 64'hDEAD_BEEF_7FFF_FFFF; pb[0] = 64'h0000_0000_7FFF_FFFF;
        pa[1] = 64'h0000_0000_8000_0000; pb[1] = 64'hFFFF_0000_FFFF_FFFF;
        pa[2] = 64'h1234_0000_FFFF_FFFF; pb[2] = 64'h0000_0000_8000_0000;
        pa[3] = 64'h0;                   pb[3] = 64'h5555_5555_1234_5678;
        for (int k = 4; k < 6; k++) begin
          seed = seed * 32'd1664525 + 32'd1013904223;
          pa[k] = {seed, seed ^ 32'hA5A5_0F0F};
          seed = seed * 32'd1664525 + 32'd1013904223;
          pb[k] = {~seed, seed};
        end
        for (int k = 0; k < 6; k++)
          do_op(s[0], m[2], m[1:0], pa[k], pb[k],
                $sformatf("R3 R4 R5 R6 sign%0d mode%0d pat%0d", s, m, k));
      end
    end

    // R7: wrap modulo 2^64
    do_op(1'b1, 1'b0, 2'b00, 64'hFFFF_FFFF, 64'hFFFF_FFFF, "R7 load big");
    do_op(1'b1, 1'b1, 2'b10, 64'hFFFF_FFFF, 64'hFFFF_FFFF, "R7 wrap add");
    chk(m_acc == 64'hFFFF_FFFC_0000_0002, "R7 wrapped value", m_acc, 64'hFFFF_FFFC_0000_0002);
    do_op(1'b1, 1'b0, 2'b11, 64'h0000_0002, 64'h8000_0000, "R7 sub");
    do_op(1'b0, 1'b1, 2'b01, 64'h0000_0001, 64'h0000_0001, "R5 negate one");
    do_op(1'b0, 1'b0, 2'b10, 64'h0000_0003, 64'hFFFF_FFFF, "R7 signed wrap add");

    // R8: every illegal field value, bad opcode, bad function codes
    for (int f = 0; f < 32; f++) begin
      logic [4:0] fv;
      fv = f[4:0];
      if (!(fv[0] && !fv[4]))
        do_bad(mk_instr(1'b0, fv, 5'd7), $sformatf("R8 field %0d", f));
    end
    do_bad({6'b000001, mk_instr(1'b0, 5'b00101, 5'd1)[25:0]}, "R8 opcode");
    do_bad({mk_instr(1'b0, 5'b00101, 5'd1)[31:6], 6'b011010}, "R8 funct 1a");
    do_bad({mk_instr(1'b0, 5'b00101, 5'd1)[31:6], 6'b111000}, "R8 funct 38");

    // R9: idle cycles with a legal-looking word on the bus
    @(negedge clk);
    instr = mk_instr(1'b0, 5'b00101, 5'd2);
    src_a = 64'h55;
    src_b = 64'h66;
    #1;
    chk(!wb_valid && !illegal, "R9 idle flags", {62'h0, wb_valid, illegal}, 64'h0);
    @(negedge clk);
    @(negedge clk);
    check_regs("R9 idle regs");
    // R2: upper halves stay zero after all of the above
    chk(hi_q[63:32] == 0 && lo_q[63:32] == 0, "R2 upper zero", {hi_q[63:32], lo_q[63:32]}, 64'h0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule